// File: doc/BRIEF.md
# Chainable Serial Converter Input Front End

This block is the digital side of a 12-bit converter that takes its code serially and can be cascaded with identical parts. Serial data is clocked into a 12-bit shift register, MSB first, by any one of four strobe pins. Three of the strobe pins act on a falling edge and one acts on a rising edge. The shift register's top bit is brought out as a serial output, so it can feed the serial input of the next device in a chain.

A second 12-bit holding register supplies the parallel conversion code. It copies the shift register while both active-low load inputs are low. An asynchronous active-low clear forces the holding register to zero and leaves the shift register untouched.

All strobe and data pins are sampled against a system clock, so the strobe network reduces to one synchronous shift enable. To fill a chain of N devices, 12·N bits are sent with the farthest device's word first. Then all load inputs are pulsed together.

Top module: `dchain_dac_front`

## Requirements
- R1: While `rst_n` is low, and after it is released, `dac_code` is 0 and `sdo` is 0 until the first shift or load.
- R2: Each shift moves the register one place toward the MSB and enters the sampled `sdi` at bit 0. `sdo` is the register MSB, so a bit entered on `sdi` appears on `sdo` after 12 shifts.
- R3: Strobe pins 0, 1 and 3 are idle high and shift on a high-to-low transition. Strobe pin 2 is idle low and shifts on a low-to-high transition. The return of a strobe to its idle level causes no shift.
- R4: A shift happens only when exactly one strobe makes its active transition while every other strobe stays at its idle level. Two simultaneous active transitions cause no shift. An active transition while another strobe is away from idle also causes no shift.
- R5: `sdo` changes only as the result of a shift.
- R6: While `ld_a_n` and `ld_b_n` are both low, `dac_code` takes the shift-register value on every clock, one clock late. With only one of them low, `dac_code` holds.
- R7: `clr_n` low forces `dac_code` to 0 at once, without a clock edge. This takes priority over loading.
- R8: The clear does not change the shift register, so a later load restores the word shifted in before the clear.
- R9: With two devices chained `sdo` to `sdi`, a 24-bit stream (downstream word first) followed by one load leaves each device's `dac_code` holding its own 12-bit word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock sampling all pins |
| rst_n | input | 1 | Asynchronous active-low system reset |
| stb | input | 4 | Strobe pins; bit 2 active rising, the others active falling |
| sdi | input | 1 | Serial data input |
| ld_a_n | input | 1 | First active-low load enable |
| ld_b_n | input | 1 | Second active-low load enable |
| clr_n | input | 1 | Asynchronous active-low clear of the holding register |
| sdo | output | 1 | Serial output, shift-register MSB |
| dac_code | output | 12 | Holding-register code |

## Verification
The bench sends words through a two-device chain on each strobe pin in turn. A design that shifted on both strobe edges, or that reversed the bit order, would leave scrambled codes in both devices. Directed tests drive two strobes together, and one strobe while another is parked away from idle. A design that counted any edge would absorb an extra bit and corrupt the word it later loads. Other tests pulse only one load enable, assert clear between clock edges while a load is requested, and reload after the clear. These catch an OR-ed load, a synchronous or lower-priority clear, and a clear that also wipes the shift register.

// File: rtl/dchain_dac_front.sv
module dchain_dac_front #(
  parameter int WIDTH = 12,
  parameter int NSTB  = 4,
  parameter logic [NSTB-1:0] RISE_MASK = 4'b0100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSTB-1:0]  stb,
  input  logic             sdi,
  input  logic             ld_a_n,
  input  logic             ld_b_n,
  input  logic             clr_n,
  output logic             sdo,
  output logic [WIDTH-1:0] dac_code
);

  localparam logic [NSTB-1:0] IDLE = ~RISE_MASK;

  logic [NSTB-1:0]  stb_q, stb_qq;
  logic [NSTB-1:0]  act, quiet;
  logic             sdi_q;
  logic             shift_en;
  logic [WIDTH-1:0] sr;
  logic             hold_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q  <= IDLE;
      stb_qq <= IDLE;
      sdi_q  <= 1'b0;
    end else begin
      stb_q  <= stb;
      stb_qq <= stb_q;
      sdi_q  <= sdi;
    end
  end

  for (genvar i = 0; i < NSTB; i++) begin : g_edge
    assign act[i]   = (stb_qq[i] == IDLE[i]) && (stb_q[i] != IDLE[i]);
    assign quiet[i] = (stb_qq[i] == IDLE[i]) && (stb_q[i] == IDLE[i]);
  end

  assign shift_en = $onehot(act) && ((act | quiet) == {NSTB{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr <= '0;
    else if (shift_en) sr <= {sr[WIDTH-2:0], sdi_q};
  end

  assign sdo = sr[WIDTH-1];

  assign hold_rst_n = rst_n & clr_n;

  always_ff @(posedge clk or negedge hold_rst_n) begin
    if (!hold_rst_n)              dac_code <= '0;
    else if (!ld_a_n && !ld_b_n)  dac_code <= sr;
  end

endmodule

module dchain_dac_front_chk #(
  parameter int WIDTH = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ld_a_n,
  input logic             ld_b_n,
  input logic             clr_n,
  input logic             sdo,
  input logic [WIDTH-1:0] dac_code,
  input logic [WIDTH-1:0] sr,
  input logic             shift_en
);

  a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> dac_code == '0);

  a_r6_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_a_n && !ld_b_n && clr_n) |=> (!clr_n || dac_code == $past(sr)));

  a_r6_hold_single: assert property (@(posedge clk) disable iff (!rst_n)
    ((ld_a_n || ld_b_n) && clr_n) |=> (!clr_n || $stable(dac_code)));

  a_r8_sr_only_on_shift: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(sr));

  a_r5_sdo_only_on_shift: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(sdo));

  a_r2_msb_advance: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> sdo == $past(sr[WIDTH-2]));

endmodule

bind dchain_dac_front dchain_dac_front_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .ld_a_n(ld_a_n), .ld_b_n(ld_b_n), .clr_n(clr_n),
  .sdo(sdo), .dac_code(dac_code), .sr(sr), .shift_en(shift_en)
);

// File: tb/dchain_dac_front_tb_top.sv
module dchain_dac_front_tb_top;

  localparam int CLK_P = 10;
  localparam int W = 12;
  localparam logic [3:0] IDLE = 4'b1011;
  localparam int NV = 6;
  localparam logic [25:0] VEC [NV] = '{
    {2'd0, 12'hA5C, 12'h3F0},
    {2'd1, 12'hFFF, 12'h000},
    {2'd2, 12'h001, 12'h800},
    {2'd3, 12'h9E7, 12'h5A1},
    {2'd2, 12'h000, 12'hFFF},
    {2'd0, 12'h7FF, 12'hC3C}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] stb = IDLE;
  logic sdi = 1'b0, ld_a_n = 1'b1, ld_b_n = 1'b1, clr_n = 1'b1;
  logic sdo_a, sdo_b;
  logic [W-1:0] code_a, code_b;
  int checks = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  dchain_dac_front dut_i (
    .clk(clk), .rst_n(rst_n), .stb(stb), .sdi(sdi), .ld_a_n(ld_a_n),
    .ld_b_n(ld_b_n), .clr_n(clr_n), .sdo(sdo_a), .dac_code(code_a));

  dchain_dac_front chain_i (
    .clk(clk), .rst_n(rst_n), .stb(stb), .sdi(sdo_a), .ld_a_n(ld_a_n),
    .ld_b_n(ld_b_n), .clr_n(clr_n), .sdo(sdo_b), .dac_code(code_b));

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic send_bit(input int sel, input logic b);
    @(negedge clk);
    sdi = b;
    stb[sel] = ~IDLE[sel];
    repeat (3) @(negedge clk);
    stb[sel] = IDLE[sel];
    repeat (2) @(negedge clk);
  endtask

  task automatic send_word(input int sel, input logic [W-1:0] w);
    for (int k = W-1; k >= 0; k--) send_bit(sel, w[k]);
  endtask

  task automatic load_pulse();
    @(negedge clk);
    ld_a_n = 1'b0; ld_b_n = 1'b0;
    @(negedge clk);
    ld_a_n = 1'b1; ld_b_n = 1'b1;
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "code in reset", code_a, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "code after reset", code_b, '0);
    check("R1", "sdo after reset", {11'd0, sdo_a}, 12'd0);

    // R9 / R2 / R3 chain vectors, one strobe pin each
    for (int v = 0; v < NV; v++) begin
      send_word(int'(VEC[v][25:24]), VEC[v][11:0]);
      send_word(int'(VEC[v][25:24]), VEC[v][23:12]);
      check("R2", "upstream sdo", {11'd0, sdo_a}, {11'd0, VEC[v][23]});
      check("R2", "downstream sdo", {11'd0, sdo_b}, {11'd0, VEC[v][11]});
      load_pulse();
      check("R9", "upstream word", code_a, VEC[v][23:12]);
      check("R9", "downstream word", code_b, VEC[v][11:0]);
    end

    // R6 single enable has no effect
    send_word(1, 12'h6B2);
    @(negedge clk); ld_a_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R6", "ld_a_n alone", code_a, 12'h7FF);
    ld_a_n = 1'b1; ld_b_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R6", "ld_b_n alone", code_a, 12'h7FF);
    ld_b_n = 1'b1;
    load_pulse();
    check("R6", "both enables upstream", code_a, 12'h6B2);
    check("R6", "both enables downstream", code_b, 12'h7FF);

    // R4 disqualified strobe edges
    @(negedge clk); sdi = 1'b1; stb[0] = 1'b0; stb[1] = 1'b0;
    repeat (3) @(negedge clk); stb[1] = 1'b1;
    repeat (3) @(negedge clk); stb[1] = 1'b0;
    repeat (3) @(negedge clk); stb[2] = 1'b1;
    repeat (3) @(negedge clk); stb = IDLE;
    repeat (3) @(negedge clk);
    check("R5", "sdo unchanged", {11'd0, sdo_a}, 12'd0);
    load_pulse();
    check("R4", "no shift on conflicting strobes", code_a, 12'h6B2);

    // R7 asynchronous clear with priority, R8 shift register kept
    @(negedge clk); ld_a_n = 1'b0; ld_b_n = 1'b0;
    #1 clr_n = 1'b0;
    #1 check("R7", "immediate clear", code_a, '0);
    repeat (2) @(negedge clk);
    check("R7", "clear over load", code_b, '0);
    ld_a_n = 1'b1; ld_b_n = 1'b1;
    @(negedge clk); clr_n = 1'b1;
    @(negedge clk);
    check("R7", "stays clear", code_a, '0);
    load_pulse();
    check("R8", "upstream restored", code_a, 12'h6B2);
    check("R8", "downstream restored", code_b, 12'h7FF);

    // R6 tracking while both enables held low
    @(negedge clk); ld_a_n = 1'b0; ld_b_n = 1'b0;
    send_bit(3, 1'b1);
    check("R6", "tracking upstream", code_a, 12'hD65);
    check("R6", "tracking downstream", code_b, 12'hFFE);
    ld_a_n = 1'b1; ld_b_n = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule